// File: doc/BRIEF.md
# Pipelined zero-turnaround synchronous SRAM

This block is a single-port synchronous memory with a shared command path. It accepts a read or a write on every enabled clock, in any order, with no idle cycles between them. Every command is registered on the rising edge. A read returns its word two enabled edges later through an output register. A write takes its data from the data input at that same two-edge offset. Because read and write data use the same slot, a mixed stream never needs a bus turnaround gap.

Two address stages hold commands whose data phase has not happened yet. A read that arrives right behind a write to the same word would miss the new value in the array. The block merges the arriving write data into that read per byte lane. A low-active clock enable freezes the whole pipeline without deselecting it. A load/advance input either starts a new access or steps a two-bit burst counter, in linear or interleaved order.

Top module: `pipe_sram`

## Requirements
- R1: While reset is held, and on the first clock after it, `dout_vld` and `dq_oe` are low.
- R2: A load (`adv_ld_n` low) starts an access only when `ce1_n`=0, `ce2`=1 and `ce3_n`=0. Any other combination is a deselect: nothing is written and no read data is produced.
- R3: A read loaded at enabled edge E0 puts the addressed word on `dout`, with `dout_vld` high, right after enabled edge E2. E2 is the second enabled edge after E0.
- R4: A write loaded at enabled edge E0 takes `din` at enabled edge E2. Lane 0 is bits [8:0] and is written only when `bw_n[0]` is 0 at E0. Lane 1 is bits [17:9] and is written only when `bw_n[1]` is 0 at E0. Each lane keeps its parity bit.
- R5: Reads and writes in any mix are accepted on consecutive enabled edges, and every read returns the newest data written before it.
- R6: A read loaded one enabled edge after a write to the same address returns the new data, merged per lane with the old contents.
- R7: While `cen_n` is 1 at an edge, no state changes. `dout` and `dout_vld` hold, `din` is ignored, and a selected access stays selected.
- R8: With `adv_ld_n` high, the next address keeps the upper bits of the last loaded address. Its two low bits are base+k mod 4 when `burst_lin` is 1, or base XOR k when `burst_lin` is 0, where k counts advances since the load. The access kind and selection come from the last load.
- R9: Advancing after a deselecting load stays deselected.
- R10: `dq_oe` equals `dout_vld` AND NOT `oe_n`, with no clock involved. It is therefore low in write data slots and in deselected slots.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cen_n | input | 1 | Clock enable, active low |
| ce1_n | input | 1 | Chip enable, active low |
| ce2 | input | 1 | Chip enable, active high |
| ce3_n | input | 1 | Chip enable, active low |
| we_n | input | 1 | Write command, active low |
| bw_n | input | NL | Byte-lane write strobes, active low |
| adv_ld_n | input | 1 | 0 loads a new address, 1 advances the burst |
| burst_lin | input | 1 | 1 linear burst order, 0 interleaved |
| addr | input | AW | Word address |
| din | input | NL*LANE | Write data, sampled in the data slot |
| oe_n | input | 1 | Asynchronous output enable, active low |
| dout | output | NL*LANE | Registered read data |
| dout_vld | output | 1 | `dout` carries read data for this slot |
| dq_oe | output | 1 | Drive enable for an external data bus |

## Verification
The hardest case to reach is a read loaded one enabled edge after a partial-lane write to the same word. That read's array access happens at the same edge as the write's data arrives, so only the forward path can supply the new value. Clock-enable stalls placed inside that window must not change the result. The stimulus confines random traffic to sixteen words, so same-address pairs occur often. It mixes random strobes, bursts and stalls, and a directed sequence builds the exact write-then-read pair. A reference model in the bench tracks every command through the two-slot pipeline.

// File: rtl/pipe_sram.sv
module pipe_sram #(
  parameter int AW = 10,
  parameter int LANE = 9,
  parameter int NL = 2,
  localparam int W = NL * LANE,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cen_n,
  input  logic          ce1_n,
  input  logic          ce2,
  input  logic          ce3_n,
  input  logic          we_n,
  input  logic [NL-1:0] bw_n,
  input  logic          adv_ld_n,
  input  logic          burst_lin,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  din,
  input  logic          oe_n,
  output logic [W-1:0]  dout,
  output logic          dout_vld,
  output logic          dq_oe
);

  logic [W-1:0] mem [DEPTH];

  logic          last_v, last_we;
  logic [AW-1:0] base;
  logic [1:0]    cnt;

  logic          a1_v, a1_we, a2_v, a2_we;
  logic [NL-1:0] a1_bw, a2_bw;
  logic [AW-1:0] a1_addr, a2_addr;
  logic [W-1:0]  rd_buf, fwd;

  wire en = !cen_n;
  wire sel_in = !ce1_n && ce2 && !ce3_n;
  wire [1:0] nxt = cnt + 2'd1;
  wire [1:0] lo_lin = base[1:0] + nxt;
  wire [1:0] lo = burst_lin ? lo_lin : (base[1:0] ^ nxt);
  wire i_v = adv_ld_n ? last_v : sel_in;
  wire i_we = adv_ld_n ? last_we : !we_n;
  wire [AW-1:0] i_addr = adv_ld_n ? {base[AW-1:2], lo} : addr;
  wire hit = a2_v && a2_we && (a2_addr == a1_addr);

  for (genvar g = 0; g < NL; g++) begin : g_lane
    assign fwd[g*LANE +: LANE] = (hit && !a2_bw[g]) ? din[g*LANE +: LANE]
                                                    : mem[a1_addr][g*LANE +: LANE];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_v <= 1'b0; last_we <= 1'b0; base <= '0; cnt <= '0;
      a1_v <= 1'b0; a1_we <= 1'b0; a1_bw <= '1; a1_addr <= '0;
      a2_v <= 1'b0; a2_we <= 1'b0; a2_bw <= '1; a2_addr <= '0;
      rd_buf <= '0; dout <= '0; dout_vld <= 1'b0;
    end else if (en) begin
      if (adv_ld_n) begin
        cnt <= nxt;
      end else begin
        cnt <= '0;
        base <= addr;
        last_v <= sel_in;
        last_we <= !we_n;
      end
      a1_v <= i_v; a1_we <= i_we; a1_bw <= bw_n; a1_addr <= i_addr;
      a2_v <= a1_v; a2_we <= a1_we; a2_bw <= a1_bw; a2_addr <= a1_addr;
      rd_buf <= fwd;
      dout_vld <= a2_v && !a2_we;
      if (a2_v && !a2_we) dout <= rd_buf;
    end
  end

  always_ff @(posedge clk) begin
    if (en && a2_v && a2_we)
      for (int g = 0; g < NL; g++)
        if (!a2_bw[g]) mem[a2_addr][g*LANE +: LANE] <= din[g*LANE +: LANE];
  end

  assign dq_oe = dout_vld && !oe_n;

  p_stall_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cen_n |=> ($stable(dout) && $stable(dout_vld)));
  p_write_slot_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (en && a2_v && a2_we) |=> !dout_vld);
  p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld_n && !sel_in) |=> !a1_v);
  p_adv_kind_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (en && adv_ld_n) |=> (a1_v == $past(last_v)));
  p_load_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !adv_ld_n) |=> (cnt == 2'd0));
  p_read_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dout_vld) |-> $past(en));

endmodule

// File: tb/test_pipe_sram.sv
`timescale 1ns/1ps
module test_pipe_sram;
  logic clk = 0, rst_n = 0;
  logic cen_n = 0, ce1_n = 1, ce2 = 0, ce3_n = 1, we_n = 1, adv_ld_n = 0;
  logic burst_lin = 1, oe_n = 0;
  logic [1:0] bw_n = 2'b11;
  logic [9:0] addr = '0;
  logic [17:0] din = '0;
  logic [17:0] dout;
  logic dout_vld, dq_oe;

  int checks = 0, fails = 0;

  pipe_sram i_pipe_sram (.clk(clk), .rst_n(rst_n), .cen_n(cen_n), .ce1_n(ce1_n),
    .ce2(ce2), .ce3_n(ce3_n), .we_n(we_n), .bw_n(bw_n), .adv_ld_n(adv_ld_n),
    .burst_lin(burst_lin), .addr(addr), .din(din), .oe_n(oe_n), .dout(dout),
    .dout_vld(dout_vld), .dq_oe(dq_oe));

  always #2 clk = ~clk;

  logic [17:0] refm [16];
  logic mv1 = 0, mwe1 = 0, mv2 = 0, mwe2 = 0, mlast_v = 0, mlast_we = 0;
  logic [1:0] mbw1 = 2'b11, mbw2 = 2'b11, mcnt = 0;
  logic [3:0] ma1 = 0, ma2 = 0, mbase = 0;
  logic exp_vld = 0;
  logic [17:0] exp_dout = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    logic iv, iwe;
    logic [3:0] ia;
    logic [1:0] lo;
    if (cen_n) return;
    if (adv_ld_n) begin
      mcnt = mcnt + 2'd1;
      lo = burst_lin ? mbase[1:0] + mcnt : mbase[1:0] ^ mcnt;
      iv = mlast_v; iwe = mlast_we; ia = {mbase[3:2], lo};
    end else begin
      iv = !ce1_n && ce2 && !ce3_n; iwe = !we_n; ia = addr[3:0];
      mbase = addr[3:0]; mcnt = 0; mlast_v = iv; mlast_we = iwe;
    end
    if (mv2 && mwe2) begin
      if (!mbw2[0]) refm[ma2][8:0] = din[8:0];
      if (!mbw2[1]) refm[ma2][17:9] = din[17:9];
    end
    exp_vld = mv2 && !mwe2;
    if (exp_vld) exp_dout = refm[ma2];
    mv2 = mv1; mwe2 = mwe1; mbw2 = mbw1; ma2 = ma1;
    mv1 = iv; mwe1 = iwe; mbw1 = bw_n; ma1 = ia;
  endtask

  task automatic cyc(input logic cen, input logic [2:0] ce, input logic we,
                     input logic [1:0] bw, input logic adv, input logic [3:0] a,
                     input logic [17:0] d, input logic oe, input string tag);
    cen_n = cen; {ce1_n, ce2, ce3_n} = ce; we_n = we; bw_n = bw;
    adv_ld_n = adv; addr = {6'd0, a}; din = d; oe_n = oe;
    @(posedge clk);
    model_edge();
    @(negedge clk);
    chk(tag, dout_vld, exp_vld);
    if (exp_vld) chk(tag, dout, exp_dout);
    chk("R10", dq_oe, exp_vld && !oe);
  endtask

  localparam logic [2:0] SEL = 3'b010;

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", dout_vld, 0);
    chk("R1", dq_oe, 0);
    rst_n = 1;
    cyc(0, 3'b101, 1, 2'b11, 0, 0, 0, 0, "R1");
    for (int i = 0; i < 16; i++) cyc(0, SEL, 0, 2'b00, 0, 4'(i), 18'(i * 7919), 0, "R4");
    for (int i = 0; i < 16; i++) cyc(0, SEL, 1, 2'b11, 0, 4'(i), 18'h3ffff, 0, "R3");
    // R6: read right behind a partial write to the same word
    cyc(0, SEL, 0, 2'b10, 0, 4'd3, 0, 0, "R6");
    cyc(0, SEL, 1, 2'b11, 0, 4'd3, 0, 0, "R6");
    cyc(0, SEL, 1, 2'b11, 0, 4'd9, 18'h155, 0, "R6");
    cyc(0, SEL, 1, 2'b11, 0, 4'd9, 18'h2aaaa, 0, "R6");
    cyc(0, SEL, 1, 2'b11, 0, 4'd9, 0, 0, "R6");
    // R7: stalls inside the write-then-read window, din toggles while held
    cyc(0, SEL, 0, 2'b01, 0, 4'd5, 0, 0, "R7");
    cyc(1, SEL, 1, 2'b11, 0, 4'd5, 18'h3ffff, 0, "R7");
    cyc(0, SEL, 1, 2'b11, 0, 4'd5, 18'h3ffff, 0, "R7");
    cyc(1, 3'b101, 1, 2'b11, 0, 4'd0, 18'h11111, 0, "R7");
    cyc(0, SEL, 1, 2'b11, 0, 4'd5, 18'h2c3a1, 0, "R7");
    cyc(1, SEL, 1, 2'b11, 0, 4'd5, 18'h0, 0, "R7");
    cyc(0, 3'b101, 1, 2'b11, 0, 4'd5, 0, 0, "R7");
    cyc(0, 3'b101, 1, 2'b11, 0, 4'd5, 0, 0, "R7");
    // R2: each non-selecting chip-enable combination writes nothing
    for (int c = 0; c < 8; c++)
      if (3'(c) != SEL) cyc(0, 3'(c), 0, 2'b00, 0, 4'd7, 18'h0, 0, "R2");
    cyc(0, SEL, 1, 2'b11, 0, 4'd7, 0, 0, "R2");
    cyc(0, 3'b101, 1, 2'b11, 0, 0, 0, 0, "R2");
    cyc(0, 3'b101, 1, 2'b11, 0, 0, 0, 0, "R2");
    // R8: linear then interleaved bursts
    burst_lin = 1;
    cyc(0, SEL, 1, 2'b11, 0, 4'd5, 0, 0, "R8");
    for (int k = 0; k < 3; k++) cyc(0, SEL, 1, 2'b11, 1, 0, 0, 0, "R8");
    burst_lin = 0;
    cyc(0, SEL, 1, 2'b11, 0, 4'd6, 0, 0, "R8");
    for (int k = 0; k < 3; k++) cyc(0, SEL, 1, 2'b11, 1, 0, 0, 0, "R8");
    cyc(0, SEL, 0, 2'b00, 0, 4'd13, 18'h0, 0, "R8");
    for (int k = 0; k < 3; k++) cyc(0, SEL, 1, 2'b11, 1, 0, 18'(k * 1111 + 5), 0, "R8");
    // R9: advance after a deselect stays idle
    cyc(0, 3'b000, 1, 2'b11, 0, 4'd2, 0, 0, "R9");
    for (int k = 0; k < 4; k++) cyc(0, SEL, 0, 2'b00, 1, 0, 18'h3ffff, 0, "R9");
    // R10: output enable high hides read data
    cyc(0, SEL, 1, 2'b11, 0, 4'd1, 0, 1, "R10");
    cyc(0, SEL, 1, 2'b11, 0, 4'd2, 0, 1, "R10");
    cyc(0, SEL, 0, 2'b00, 0, 4'd2, 0, 1, "R10");
    cyc(0, 3'b101, 1, 2'b11, 0, 0, 18'h1234, 0, "R10");
    // R5: random mixed streams with stalls and bursts
    for (int i = 0; i < 6000; i++) begin
      logic [2:0] ce;
      if (i % 500 == 0) burst_lin = 1'($urandom);
      ce = ($urandom % 8 == 0) ? 3'($urandom) : SEL;
      cyc(1'($urandom % 5 == 0), ce, 1'($urandom), 2'($urandom),
          1'($urandom % 4 == 0), 4'($urandom), 18'($urandom),
          1'($urandom % 8 == 0), "R5");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule